// File: doc/BRIEF.md
# Data-Phase Timeout Terminator

This block sits between a bus slave front end and the user logic behind it. The front end sends it an address-acknowledge pulse, the direction of the transfer, and its request strobes: a chip select plus a read enable and a write enable. The block passes the strobes to the user logic. It also passes the user logic's read and write acknowledges, and the read data, back to the bus side.

While a transaction is outstanding, an internal counter measures the data phase. The user logic has a fixed window in which to answer. If it does not, the block ends the transaction itself for exactly one clock. In that clock it drops the strobes toward the user logic and raises the matching bus-side data acknowledge. A read returns all-zero data. The requester gets no error and no other sign of the timeout.

A sticky status bit records that at least one forced completion has occurred, so a bench can observe it. A parameter removes the timer entirely, which leaves only the pass-through paths. All pins are plain control and data wires. There is no valid/ready pair, because neither side can stall the other: the bus side has to take each acknowledge in the cycle it is presented.

Top module: `dpt_terminator`

## Requirements
- R1: While reset is high and in the first cycle after it, neither bus acknowledge is high, the timeout status bit reads 0, and the strobes follow their inputs.
- R2: Outside a forced cycle, the user chip select and enables equal the request inputs. Each user acknowledge appears on the matching bus acknowledge in the same cycle. Whenever the user read acknowledge is high, the bus read data equals the user read data.
- R3: Call the cycle in which addr_ack is sampled high cycle 0. If no user acknowledge arrives in cycles 1 to TIMEOUT (default 128), a forced acknowledge is presented in cycle TIMEOUT+1 and in no earlier cycle.
- R4: A forced completion of a read (req_rnw was 1 at addr_ack) raises bus_rd_ack with bus_rd_data all zero, and keeps bus_wr_ack low.
- R5: A forced completion of a write (req_rnw was 0 at addr_ack) raises bus_wr_ack and keeps bus_rd_ack low.
- R6: In the forced cycle, usr_cs, usr_rd_ce and usr_wr_ce are all 0, whatever the request inputs are.
- R7: A forced acknowledge lasts one cycle. The block then returns to idle, and the next addr_ack starts a fresh window.
- R8: A user acknowledge in cycle TIMEOUT, which is the last cycle of the window, wins. The real data is returned and no forced acknowledge follows.
- R9: A user acknowledge in any cycle 1 to TIMEOUT ends the window. No forced acknowledge follows for that transaction.
- R10: timeout_seen becomes 1 in the cycle after a forced completion. It stays 1 until reset.
- R11: With TIMER_EN = 0, no forced acknowledge is ever produced and timeout_seen stays 0.
- R12: A user acknowledge in the same cycle as addr_ack completes the transaction. No window is opened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_ack | input | 1 | One-cycle pulse: the address phase has been accepted |
| req_rnw | input | 1 | Transfer direction, sampled with addr_ack; 1 = read, 0 = write |
| req_cs | input | 1 | Chip select from the front end |
| req_rd_ce | input | 1 | Read enable from the front end |
| req_wr_ce | input | 1 | Write enable from the front end |
| usr_rd_ack | input | 1 | Read acknowledge from the user logic |
| usr_wr_ack | input | 1 | Write acknowledge from the user logic |
| usr_rd_data | input | DW | Read data from the user logic |
| usr_cs | output | 1 | Gated chip select to the user logic |
| usr_rd_ce | output | 1 | Gated read enable to the user logic |
| usr_wr_ce | output | 1 | Gated write enable to the user logic |
| bus_rd_ack | output | 1 | Read data acknowledge to the bus |
| bus_wr_ack | output | 1 | Write data acknowledge to the bus |
| bus_rd_data | output | DW | Read data to the bus; zero on a forced read |
| timeout_seen | output | 1 | Sticky flag: a forced completion has occurred |

## Verification
The pass-through results, meaning the user acknowledges, the read data and the strobes, are combinational. They are due in the same cycle as their stimulus. The bench drives inputs at the falling edge and samples one nanosecond later, inside that same cycle. A forced acknowledge is due exactly TIMEOUT+1 cycles after the cycle in which addr_ack was sampled, and the timeout status bit one cycle after that. The bench counts cycles from addr_ack, checks every cycle of every window against functions of the chosen user latency, and checks the cycle after each forced acknowledge for its absence and for the status bit.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FORCE = 2'd2
  } dpt_state_e;
endpackage

// File: rtl/dpt_cycle_counter.sv
module dpt_cycle_counter #(
  parameter int LIMIT = 128,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic step,
  output logic hit
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= CW'(1);
    else if (step) cnt <= cnt + CW'(1);
  end

  assign hit = (cnt == CW'(LIMIT));
endmodule

// File: rtl/dpt_ctrl.sv
module dpt_ctrl
  import dpt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic addr_ack,
  input  logic req_rnw,
  input  logic usr_ack,
  input  logic hit,
  output logic load,
  output logic step,
  output logic force_now,
  output logic force_rd,
  output logic sticky
);
  dpt_state_e state, state_nx;
  logic       rd_q;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:  if (addr_ack && !usr_ack) state_nx = ST_WAIT;
      ST_WAIT:  if (usr_ack) state_nx = ST_IDLE;
                else if (hit) state_nx = ST_FORCE;
      ST_FORCE: state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      rd_q   <= 1'b0;
      sticky <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_IDLE && addr_ack) rd_q <= req_rnw;
      if (state == ST_FORCE) sticky <= 1'b1;
    end
  end

  assign load      = (state == ST_IDLE) && addr_ack && !usr_ack;
  assign step      = (state == ST_WAIT) && !usr_ack && !hit;
  assign force_now = (state == ST_FORCE);
  assign force_rd  = rd_q;
endmodule

// File: rtl/dpt_terminator.sv
module dpt_terminator #(
  parameter int TIMER_EN = 1,
  parameter int TIMEOUT  = 128,
  parameter int DW       = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_ack,
  input  logic          req_rnw,
  input  logic          req_cs,
  input  logic          req_rd_ce,
  input  logic          req_wr_ce,
  input  logic          usr_rd_ack,
  input  logic          usr_wr_ack,
  input  logic [DW-1:0] usr_rd_data,
  output logic          usr_cs,
  output logic          usr_rd_ce,
  output logic          usr_wr_ce,
  output logic          bus_rd_ack,
  output logic          bus_wr_ack,
  output logic [DW-1:0] bus_rd_data,
  output logic          timeout_seen
);
  logic force_now;
  logic force_rd;
  logic sticky;

  generate
    if (TIMER_EN != 0) begin : g_timer
      logic load, step, hit;

      dpt_cycle_counter #(.LIMIT(TIMEOUT)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .step (step),
        .hit  (hit)
      );

      dpt_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .addr_ack  (addr_ack),
        .req_rnw   (req_rnw),
        .usr_ack   (usr_rd_ack | usr_wr_ack),
        .hit       (hit),
        .load      (load),
        .step      (step),
        .force_now (force_now),
        .force_rd  (force_rd),
        .sticky    (sticky)
      );
    end else begin : g_bypass
      assign force_now = 1'b0;
      assign force_rd  = 1'b0;
      assign sticky    = 1'b0;
    end
  endgenerate

  assign usr_cs       = req_cs    & ~force_now;
  assign usr_rd_ce    = req_rd_ce & ~force_now;
  assign usr_wr_ce    = req_wr_ce & ~force_now;
  assign bus_rd_ack   = usr_rd_ack | (force_now &  force_rd);
  assign bus_wr_ack   = usr_wr_ack | (force_now & ~force_rd);
  assign bus_rd_data  = (force_now && !usr_rd_ack) ? '0 : usr_rd_data;
  assign timeout_seen = sticky;
endmodule

// File: rtl/dpt_terminator_chk.sv
module dpt_terminator_chk #(
  parameter int TIMER_EN = 1,
  parameter int TIMEOUT  = 128,
  parameter int DW       = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          addr_ack,
  input logic          req_rnw,
  input logic          req_cs,
  input logic          req_rd_ce,
  input logic          req_wr_ce,
  input logic          usr_rd_ack,
  input logic          usr_wr_ack,
  input logic [DW-1:0] usr_rd_data,
  input logic          usr_cs,
  input logic          usr_rd_ce,
  input logic          usr_wr_ce,
  input logic          bus_rd_ack,
  input logic          bus_wr_ack,
  input logic [DW-1:0] bus_rd_data,
  input logic          timeout_seen
);
  localparam int KW = $clog2(TIMEOUT + 2) + 1;

  logic          fr;
  logic          open_q;
  logic          rd_q;
  logic [KW-1:0] age;

  assign fr = (bus_rd_ack && !usr_rd_ack) || (bus_wr_ack && !usr_wr_ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      rd_q   <= 1'b0;
      age    <= '0;
    end else if (!open_q && addr_ack && !(usr_rd_ack || usr_wr_ack)) begin
      open_q <= 1'b1;
      rd_q   <= req_rnw;
      age    <= KW'(1);
    end else if (open_q && (bus_rd_ack || bus_wr_ack)) begin
      open_q <= 1'b0;
    end else if (open_q) begin
      age <= age + KW'(1);
    end
  end

  AST_RD_PASS: assert property (@(posedge clk) disable iff (rst)
    usr_rd_ack |-> (bus_rd_ack && bus_rd_data == usr_rd_data)); // R2
  AST_WR_PASS: assert property (@(posedge clk) disable iff (rst)
    usr_wr_ack |-> bus_wr_ack); // R2

  generate
    if (TIMER_EN != 0) begin : g_t
      AST_FORCE_ONLY_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        fr |-> (open_q && age == KW'(TIMEOUT + 1))); // R3
      AST_FORCE_DUE: assert property (@(posedge clk) disable iff (rst)
        (open_q && age == KW'(TIMEOUT + 1)) |-> (bus_rd_ack || bus_wr_ack)); // R3
      AST_FORCED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (fr && rd_q) |-> (bus_rd_ack && !bus_wr_ack && bus_rd_data == '0)); // R4
      AST_FORCED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (fr && !rd_q) |-> (bus_wr_ack && !bus_rd_ack)); // R5
      AST_STROBES_GATED: assert property (@(posedge clk) disable iff (rst)
        fr |-> (!usr_cs && !usr_rd_ce && !usr_wr_ce)); // R6
      AST_FORCE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        fr |=> !fr); // R7
      AST_STICKY_SET: assert property (@(posedge clk) disable iff (rst)
        fr |=> timeout_seen); // R10
      AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        timeout_seen |=> timeout_seen); // R10
    end else begin : g_nt
      AST_NO_TIMER_FORCE: assert property (@(posedge clk) disable iff (rst)
        !fr && !timeout_seen); // R11
    end
  endgenerate
endmodule

bind dpt_terminator dpt_terminator_chk #(
  .TIMER_EN (TIMER_EN),
  .TIMEOUT  (TIMEOUT),
  .DW       (DW)
) u_chk (.*);

// File: tb/dpt_terminator_tb.sv
module dpt_terminator_tb;
  localparam int TO = 128;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_ack = 0, req_rnw = 0, req_cs = 0, req_rd_ce = 0, req_wr_ce = 0;
  logic usr_rd_ack = 0, usr_wr_ack = 0;
  logic [DW-1:0] usr_rd_data = '0;

  logic cs_a, rce_a, wce_a, rack_a, wack_a, ts_a;
  logic [DW-1:0] rdat_a;
  logic cs_b, rce_b, wce_b, rack_b, wack_b, ts_b;
  logic [DW-1:0] rdat_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dpt_terminator #(.TIMER_EN(1), .TIMEOUT(TO), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .addr_ack(addr_ack), .req_rnw(req_rnw),
    .req_cs(req_cs), .req_rd_ce(req_rd_ce), .req_wr_ce(req_wr_ce),
    .usr_rd_ack(usr_rd_ack), .usr_wr_ack(usr_wr_ack), .usr_rd_data(usr_rd_data),
    .usr_cs(cs_a), .usr_rd_ce(rce_a), .usr_wr_ce(wce_a),
    .bus_rd_ack(rack_a), .bus_wr_ack(wack_a), .bus_rd_data(rdat_a),
    .timeout_seen(ts_a));

  dpt_terminator #(.TIMER_EN(0), .TIMEOUT(TO), .DW(DW)) u_dut_nt (
    .clk(clk), .rst(rst), .addr_ack(addr_ack), .req_rnw(req_rnw),
    .req_cs(req_cs), .req_rd_ce(req_rd_ce), .req_wr_ce(req_wr_ce),
    .usr_rd_ack(usr_rd_ack), .usr_wr_ack(usr_wr_ack), .usr_rd_data(usr_rd_data),
    .usr_cs(cs_b), .usr_rd_ce(rce_b), .usr_wr_ce(wce_b),
    .bus_rd_ack(rack_b), .bus_wr_ack(wack_b), .bus_rd_data(rdat_b),
    .timeout_seen(ts_b));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // a forced acknowledge is expected in cycle TO+1 when the user never answers in the window
  function automatic bit exp_force(int k, int lat);
    return (lat > TO) && (k == TO + 1);
  endfunction
  function automatic bit exp_rack(int k, int lat, bit rnw);
    return rnw && ((k == lat) || exp_force(k, lat));
  endfunction
  function automatic bit exp_wack(int k, int lat, bit rnw);
    return !rnw && ((k == lat) || exp_force(k, lat));
  endfunction

  // lat: cycle after addr_ack in which the user acknowledges (0 = same cycle, > TO = never)
  task automatic run_txn(input bit rnw, input int lat, input logic [DW-1:0] dat);
    int last;
    bit f;
    last = (lat > TO) ? TO + 2 : lat + 1;
    for (int k = 0; k <= last; k++) begin
      @(negedge clk);
      addr_ack    = (k == 0);
      req_rnw     = rnw;
      req_cs      = (k <= lat) || (lat > TO && k <= TO + 1);
      req_rd_ce   = req_cs && rnw;
      req_wr_ce   = req_cs && !rnw;
      usr_rd_ack  = (k == lat) && rnw;
      usr_wr_ack  = (k == lat) && !rnw;
      usr_rd_data = (k == lat) ? dat : $urandom;
      #1;
      f = exp_force(k, lat);
      if (k == TO + 1 && lat > TO) begin
        chk(rnw ? "R4 forced rd ack" : "R5 forced wr ack", {rack_a, wack_a}, {rnw, !rnw});
        if (rnw) chk("R4 zero data", rdat_a, '0);
        chk("R6 strobes gated", {cs_a, rce_a, wce_a}, 3'b000);
        chk("R3 forced at TO+1", rack_a | wack_a, 1'b1);
      end else begin
        chk(lat == TO ? "R8 ack at last cycle wins" : (lat == 0 ? "R12 same-cycle ack" : "R3 R9 no early force"),
            {rack_a, wack_a}, {exp_rack(k, lat, rnw), exp_wack(k, lat, rnw)});
        chk("R2 strobes pass", {cs_a, rce_a, wce_a}, {req_cs, req_rd_ce, req_wr_ce});
        if (k == lat && rnw) chk("R2 read data pass", rdat_a, dat);
        if (k == TO + 2) chk("R7 one-cycle force", rack_a | wack_a, 1'b0);
        if (k == TO + 2) chk("R10 sticky set", ts_a, 1'b1);
      end
      chk("R11 no timer: acks follow user", {rack_b, wack_b}, {usr_rd_ack, usr_wr_ack});
      chk("R11 no timer: strobes pass", {cs_b, rce_b, wce_b}, {req_cs, req_rd_ce, req_wr_ce});
      if (!f && k == lat && rnw) chk("R2 no-timer data", rdat_b, dat);
    end
    @(negedge clk);
    addr_ack = 0; req_cs = 0; req_rd_ce = 0; req_wr_ce = 0; usr_rd_ack = 0; usr_wr_ack = 0;
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          n_chk++; n_fail++;
          $display("FAIL watchdog actual=timeout expected=completion");
          $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
          $finish;
        end
      end
    join_none
  end

  initial begin
    int seed_dummy;
    bit rnw;
    int lat;
    seed_dummy = $urandom(32'h5eed_0042);
    req_cs = 1; req_rd_ce = 1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset acks low", {rack_a, wack_a}, 2'b00);
    chk("R1 reset sticky", ts_a, 1'b0);
    chk("R1 reset strobes pass", {cs_a, rce_a, wce_a}, 3'b110);
    @(negedge clk); rst = 0; req_cs = 0; req_rd_ce = 0;
    #1;
    chk("R1 after reset acks low", {rack_a, wack_a}, 2'b00);
    chk("R1 after reset sticky", ts_a, 1'b0);

    run_txn(1'b1, 5, 32'hA5A5_0001);
    chk("R9 no sticky after fast ack", ts_a, 1'b0);
    run_txn(1'b0, 0, 32'h0);
    run_txn(1'b1, TO, 32'hCAFE_0128);
    run_txn(1'b0, TO, 32'h0);
    chk("R8 no sticky after last-cycle ack", ts_a, 1'b0);
    run_txn(1'b1, 1000, 32'h0);
    run_txn(1'b0, 1000, 32'h0);
    run_txn(1'b1, TO - 1, 32'h1234_5678);
    chk("R10 sticky holds", ts_a, 1'b1);
    chk("R11 no-timer sticky stays 0", ts_b, 1'b0);

    for (int i = 0; i < 40; i++) begin
      rnw = $urandom_range(0, 1);
      case ($urandom_range(0, 3))
        0: lat = 1000;
        1: lat = $urandom_range(TO - 3, TO);
        default: lat = $urandom_range(0, 40);
      endcase
      run_txn(rnw, lat, $urandom);
    end
    chk("R10 sticky at end", ts_a, 1'b1);
    chk("R11 no-timer sticky at end", ts_b, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule